// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block sits between a processor core's 16-bit memory request port and an external 16-bit data bus that has two byte lanes. For each request it drives a word-aligned or byte address, one or both active-low lane enables, and the write data steered onto the right lanes. It then hands the read word back to the core with a single completion pulse.

The external device reports its width on an active-low narrow-memory input, sampled when the first data phase ends. A wide device completes a word access in one bus cycle. A byte-wide device only moves the low-lane byte in that cycle, so the block runs a second bus cycle straight after it. The second cycle uses the odd address, and the remaining byte travels on the low lane. For reads, the two low-lane bytes are merged into one word before the core sees it. Byte accesses are never split.

Top module: `bus_sizer`

## Requirements
- R1: After reset, `req_ready` is 1 while `bus_strobe` and `rsp_done` are 0, and both `bus_hi_n` and `bus_lo_n` are 1. With no bus cycle in progress, both enables stay 1.
- R2: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge, and `bus_strobe` rises in the next cycle. While `bus_ack` is 0, the bus address, enables and write data hold steady, and `req_valid` is ignored.
- R3: For a word access (`req_word`=1) the first cycle drives both enables low and bus address bit 0 as 0. If `bus_narrow_n` is 1 at the ack, the access ends after that one cycle. A read then returns `bus_din` as is, and a write drives `req_wdata` as is.
- R4: A byte access (`req_word`=0) enables only one lane. Address bit 0 = 0 selects the high lane (`bus_hi_n`=0, bits 15:8) and 1 selects the low lane (`bus_lo_n`=0, bits 7:0). A byte access is never split, whatever `bus_narrow_n` shows. A byte read returns the selected lane byte in `rsp_rdata[7:0]` with zeros above it. A byte write drives `req_wdata[7:0]` onto both lanes.
- R5: `bus_narrow_n` is sampled only at the ack of a word access's first cycle. If it is 0 there, a second bus cycle starts in the very next cycle with no idle cycle in between. Its value during wait cycles, and during the second cycle, has no effect.
- R6: In the second cycle only `bus_lo_n` is low. The bus address equals the first cycle's address with bit 0 set to 1.
- R7: A split read returns `rsp_rdata[7:0]` as the first cycle's `bus_din[7:0]` and `rsp_rdata[15:8]` as the second cycle's `bus_din[7:0]`.
- R8: A split write drives `req_wdata` in the first cycle. In the second cycle it drives `req_wdata[15:8]` on bits 7:0 (the same byte also appears on bits 15:8).
- R9: `rsp_done` is a single-cycle pulse in the cycle after the final ack of an access, with `req_ready` already 1. It occurs once per access, never between the two halves of a split access. `rsp_rdata` changes only when a read completes and holds through later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_addr | input | AW | Request byte address |
| req_wdata | input | 16 | Write word (byte writes use bits 7:0) |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result |
| bus_addr | output | AW | External bus address |
| bus_strobe | output | 1 | Bus cycle in progress |
| bus_write | output | 1 | Bus cycle is a write |
| bus_hi_n | output | 1 | High lane (15:8) enable, active low |
| bus_lo_n | output | 1 | Low lane (7:0) enable, active low |
| bus_dout | output | 16 | Write data to the bus |
| bus_din | input | 16 | Read data from the bus |
| bus_ack | input | 1 | Data phase of the current bus cycle ends |
| bus_narrow_n | input | 1 | Device is byte wide, active low |

## Verification
The bound checker watches several lane and timing rules on every cycle. It checks lane-enable legality: both lanes for a word first cycle, exactly one for a byte access, and only the low lane in a second cycle. It also checks that address and data hold during wait states, that a second cycle follows a split ack with no gap and keeps the upper address bits, that second-cycle write data is copied across lanes, and that the done pulse follows an ack. Only the bench scenarios can show data values end to end. These include the byte order of a merged split read, the lane byte picked by a byte read, the fact that a narrow indication during waits or at a byte access changes nothing, and that read data survives a later write.

// File: rtl/bus_sizer_pkg.sv
package bus_sizer_pkg;
  localparam int LANE_W = 8;
  localparam int WORD_W = 2 * LANE_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANE_W-1:0] lane_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } seq_st_e;

  // Active-low lane enables, returned as {hi_n, lo_n}.
  function automatic logic [1:0] lane_enables_n(input logic second,
                                                input logic word,
                                                input logic a0);
    if (second)    return 2'b10;
    else if (word) return 2'b00;
    else if (a0)   return 2'b10;
    else           return 2'b01;
  endfunction

  // Address bit 0 presented on the bus for the current cycle.
  function automatic logic cycle_a0(input logic second,
                                    input logic word,
                                    input logic a0);
    if (second)    return 1'b1;
    else if (word) return 1'b0;
    else           return a0;
  endfunction

  // Places write data on the lanes for the current cycle.
  function automatic word_t write_steer(input logic second,
                                        input logic word,
                                        input word_t wd);
    if (second)    return {wd[WORD_W-1:LANE_W], wd[WORD_W-1:LANE_W]};
    else if (word) return wd;
    else           return {wd[LANE_W-1:0], wd[LANE_W-1:0]};
  endfunction

  // Builds the word handed back to the core at the final ack.
  function automatic word_t read_merge(input logic split,
                                       input logic word,
                                       input logic a0,
                                       input word_t din,
                                       input lane_t first_lo);
    if (split)     return {din[LANE_W-1:0], first_lo};
    else if (word) return din;
    else if (a0)   return {{LANE_W{1'b0}}, din[LANE_W-1:0]};
    else           return {{LANE_W{1'b0}}, din[WORD_W-1:LANE_W]};
  endfunction
endpackage

// File: rtl/bsz_fsm.sv
module bsz_fsm
  import bus_sizer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_fire,
  input  logic    bus_ack,
  input  logic    word_q,
  input  logic    bus_narrow_n,
  output seq_st_e state,
  output logic    split_go,
  output logic    last_ack
);
  seq_st_e state_d;

  assign split_go = (state == ST_FIRST) && bus_ack && word_q && !bus_narrow_n;
  assign last_ack = bus_ack &&
                    (((state == ST_FIRST) && !split_go) || (state == ST_SECOND));

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:   if (req_fire) state_d = ST_FIRST;
      ST_FIRST:  if (split_go) state_d = ST_SECOND;
                 else if (bus_ack) state_d = ST_IDLE;
      ST_SECOND: if (bus_ack) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/bsz_lanes.sv
module bsz_lanes
  import bus_sizer_pkg::*;
#(
  parameter int AW = 32
) (
  input  seq_st_e         state,
  input  logic [AW-1:0]   addr_q,
  input  logic            word_q,
  input  logic            write_q,
  input  word_t           wdata_q,
  output logic [AW-1:0]   bus_addr,
  output logic            bus_strobe,
  output logic            bus_write,
  output logic            bus_hi_n,
  output logic            bus_lo_n,
  output word_t           bus_dout
);
  logic       second;
  logic [1:0] en_n;

  assign second     = (state == ST_SECOND);
  assign bus_strobe = (state != ST_IDLE);
  assign bus_write  = bus_strobe && write_q;
  assign en_n       = bus_strobe ? lane_enables_n(second, word_q, addr_q[0]) : 2'b11;
  assign bus_hi_n   = en_n[1];
  assign bus_lo_n   = en_n[0];
  assign bus_addr   = {addr_q[AW-1:1], cycle_a0(second, word_q, addr_q[0])};
  assign bus_dout   = bus_write ? write_steer(second, word_q, wdata_q) : '0;
endmodule

// File: rtl/bsz_merge.sv
module bsz_merge
  import bus_sizer_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  split_go,
  input  logic  last_ack,
  input  logic  second,
  input  logic  word_q,
  input  logic  write_q,
  input  logic  a0_q,
  input  word_t bus_din,
  output logic  rsp_done,
  output word_t rsp_rdata
);
  lane_t first_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_lo  <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= last_ack;
      if (split_go) first_lo <= bus_din[LANE_W-1:0];
      if (last_ack && !write_q)
        rsp_rdata <= read_merge(second, word_q, a0_q, bus_din, first_lo);
    end
  end
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bus_sizer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_word,
  input  logic [AW-1:0]       req_addr,
  input  logic [WORD_W-1:0]   req_wdata,
  output logic                rsp_done,
  output logic [WORD_W-1:0]   rsp_rdata,
  output logic [AW-1:0]       bus_addr,
  output logic                bus_strobe,
  output logic                bus_write,
  output logic                bus_hi_n,
  output logic                bus_lo_n,
  output logic [WORD_W-1:0]   bus_dout,
  input  logic [WORD_W-1:0]   bus_din,
  input  logic                bus_ack,
  input  logic                bus_narrow_n
);
  seq_st_e       state;
  logic          req_fire;
  logic          split_go;
  logic          last_ack;
  logic          phase2;
  logic [AW-1:0] addr_q;
  logic          word_q;
  logic          write_q;
  word_t         wdata_q;

  assign req_ready = (state == ST_IDLE);
  assign req_fire  = req_valid && req_ready;
  assign phase2    = (state == ST_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      word_q  <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (req_fire) begin
      addr_q  <= req_addr;
      word_q  <= req_word;
      write_q <= req_write;
      wdata_q <= req_wdata;
    end
  end

  bsz_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_fire     (req_fire),
    .bus_ack      (bus_ack),
    .word_q       (word_q),
    .bus_narrow_n (bus_narrow_n),
    .state        (state),
    .split_go     (split_go),
    .last_ack     (last_ack)
  );

  bsz_lanes #(.AW(AW)) u_lanes (
    .state      (state),
    .addr_q     (addr_q),
    .word_q     (word_q),
    .write_q    (write_q),
    .wdata_q    (wdata_q),
    .bus_addr   (bus_addr),
    .bus_strobe (bus_strobe),
    .bus_write  (bus_write),
    .bus_hi_n   (bus_hi_n),
    .bus_lo_n   (bus_lo_n),
    .bus_dout   (bus_dout)
  );

  bsz_merge u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .split_go  (split_go),
    .last_ack  (last_ack),
    .second    (phase2),
    .word_q    (word_q),
    .write_q   (write_q),
    .a0_q      (addr_q[0]),
    .bus_din   (bus_din),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/bus_sizer_chk.sv
module bus_sizer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          bus_strobe,
  input logic          bus_ack,
  input logic          bus_write,
  input logic          bus_hi_n,
  input logic          bus_lo_n,
  input logic [AW-1:0] bus_addr,
  input logic [15:0]   bus_dout,
  input logic          rsp_done,
  input logic          word_q,
  input logic          phase2,
  input logic          split_go
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |-> bus_hi_n && bus_lo_n);

  a_r2_hold_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe && !bus_ack |=> bus_strobe && $stable(bus_addr) && $stable(bus_hi_n)
                               && $stable(bus_lo_n) && $stable(bus_dout));

  a_r3_word_both_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe && word_q && !phase2 |-> !bus_hi_n && !bus_lo_n && !bus_addr[0]);

  a_r4_byte_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe && !word_q |-> $countones({bus_hi_n, bus_lo_n}) == 1);

  a_r5_split_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    split_go |=> phase2 && bus_strobe && !rsp_done);

  a_r6_second_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
    phase2 |-> bus_hi_n && !bus_lo_n && bus_addr[0]);

  a_r6_same_upper_addr: assert property (@(posedge clk) disable iff (!rst_n)
    split_go |=> bus_addr[AW-1:1] == $past(bus_addr[AW-1:1]));

  a_r8_second_copy: assert property (@(posedge clk) disable iff (!rst_n)
    phase2 && bus_write |-> bus_dout[7:0] == bus_dout[15:8]);

  a_r9_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(bus_strobe && bus_ack) && !bus_strobe && req_ready);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind bus_sizer bus_sizer_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .bus_strobe (bus_strobe),
  .bus_ack    (bus_ack),
  .bus_write  (bus_write),
  .bus_hi_n   (bus_hi_n),
  .bus_lo_n   (bus_lo_n),
  .bus_addr   (bus_addr),
  .bus_dout   (bus_dout),
  .rsp_done   (rsp_done),
  .word_q     (word_q),
  .phase2     (phase2),
  .split_go   (split_go)
);

// File: tb/bus_sizer_test.sv
module bus_sizer_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          rsp_done;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic          bus_strobe;
  logic          bus_write;
  logic          bus_hi_n;
  logic          bus_lo_n;
  logic [15:0]   bus_dout;
  logic [15:0]   bus_din = '0;
  logic          bus_ack = 1'b0;
  logic          bus_narrow_n = 1'b1;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 1'b0;
  logic [15:0] last_rd = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_sizer #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_strobe(bus_strobe), .bus_write(bus_write),
    .bus_hi_n(bus_hi_n), .bus_lo_n(bus_lo_n), .bus_dout(bus_dout),
    .bus_din(bus_din), .bus_ack(bus_ack), .bus_narrow_n(bus_narrow_n)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Runs one access; narrow = device reports byte width at the first ack.
  task automatic run_access(input bit wr, input bit word, input logic [AW-1:0] a,
                            input logic [15:0] wd, input bit narrow,
                            input logic [15:0] d1, input logic [15:0] d2,
                            input int waits);
    bit          split = word && narrow;
    logic [1:0]  en1 = word ? 2'b00 : (a[0] ? 2'b10 : 2'b01);
    logic [AW-1:0] a1 = {a[AW-1:1], word ? 1'b0 : a[0]};
    logic [15:0] do1 = word ? wd : {wd[7:0], wd[7:0]};
    logic [15:0] exp_rd;
    if (split)      exp_rd = {d2[7:0], d1[7:0]};
    else if (word)  exp_rd = d1;
    else if (a[0])  exp_rd = {8'h00, d1[7:0]};
    else            exp_rd = {8'h00, d1[15:8]};

    @(negedge clk);
    chk("R2 ready before request", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_word = word; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 strobe after accept", bus_strobe, 1);
    for (int i = 0; i < waits; i++) begin
      req_valid = 1'b1; req_addr = ~a; bus_narrow_n = narrow;  // R10-style noise: ignored
      @(negedge clk);
      chk("R2 address held in wait", bus_addr, a1);
      chk("R5 narrow ignored in wait", bus_hi_n & bus_lo_n, 0);
    end
    req_valid = 1'b0;
    chk("R3/R4 first-cycle address", bus_addr, a1);
    chk("R3/R4 first-cycle enables", {bus_hi_n, bus_lo_n}, en1);
    chk("R2 bus_write", bus_write, wr);
    if (wr) chk("R4/R8 first-cycle write data", bus_dout, do1);
    bus_ack = 1'b1; bus_narrow_n = !narrow; bus_din = d1;
    @(negedge clk);
    bus_ack = 1'b0; bus_narrow_n = 1'b1;
    if (split) begin
      chk("R5 second cycle follows at once", bus_strobe, 1);
      chk("R9 no done between halves", rsp_done, 0);
      chk("R6 second-cycle enables", {bus_hi_n, bus_lo_n}, 2'b10);
      chk("R6 second-cycle address", bus_addr, {a[AW-1:1], 1'b1});
      if (wr) chk("R8 second-cycle low lane", bus_dout[7:0], wd[15:8]);
      for (int i = 0; i < waits; i++) begin
        bus_narrow_n = 1'b0; bus_din = 16'hDEAD;
        @(negedge clk);
        chk("R6 second-cycle address held", bus_addr, {a[AW-1:1], 1'b1});
      end
      bus_ack = 1'b1; bus_narrow_n = 1'b0; bus_din = d2;  // R5: narrow ignored in cycle 2
      @(negedge clk);
      bus_ack = 1'b0; bus_narrow_n = 1'b1;
    end
    chk("R9 done pulse", rsp_done, 1);
    chk("R9 bus idle at done", bus_strobe, 0);
    chk("R9 ready at done", req_ready, 1);
    if (!wr) begin
      chk(split ? "R7 merged read" : (word ? "R3 word read" : "R4 byte read"), rsp_rdata, exp_rd);
      last_rd = exp_rd;
    end else begin
      chk("R9 read data kept over write", rsp_rdata, last_rd);
    end
    @(negedge clk);
    chk("R9 done is one cycle", rsp_done, 0);
    chk("R2 no request taken while busy", bus_strobe, 0);
    chk("R9 read data held", rsp_rdata, last_rd);
    chk("R1 enables idle", {bus_hi_n, bus_lo_n}, 2'b11);
  endtask

  task automatic t_reset;
    chk("R1 ready", req_ready, 1);
    chk("R1 strobe", bus_strobe, 0);
    chk("R1 done", rsp_done, 0);
    chk("R1 enables", {bus_hi_n, bus_lo_n}, 2'b11);
  endtask

  task automatic t_wide_word;
    run_access(0, 1, 32'h1000_0010, 16'h0, 0, 16'hA1B2, 16'h0, 0);
    run_access(0, 1, 32'h1000_0013, 16'h0, 0, 16'h3C4D, 16'h0, 2);  // R3 A0 forced low
    run_access(1, 1, 32'h2000_0020, 16'hBEEF, 0, 16'h0, 16'h0, 1);
  endtask

  task automatic t_bytes;
    run_access(0, 0, 32'h0000_0100, 16'h0, 1, 16'h5A66, 16'h0, 0);  // R4 high lane, narrow ignored
    run_access(0, 0, 32'h0000_0101, 16'h0, 1, 16'h5A66, 16'h0, 1);  // R4 low lane
    run_access(1, 0, 32'h0000_0102, 16'h77C3, 1, 16'h0, 16'h0, 0);
    run_access(1, 0, 32'h0000_0103, 16'h1299, 0, 16'h0, 16'h0, 2);
  endtask

  task automatic t_split_read;
    run_access(0, 1, 32'h3000_0040, 16'h0, 1, 16'hFF34, 16'h0012, 0);  // R7
    run_access(0, 1, 32'h3000_0042, 16'h0, 1, 16'h00C8, 16'hAA9E, 3);
  endtask

  task automatic t_split_write;
    run_access(1, 1, 32'h4000_0080, 16'hCAFE, 1, 16'h0, 16'h0, 0);     // R8
    run_access(1, 1, 32'h4000_0086, 16'h8135, 1, 16'h0, 16'h0, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wide_word();
    t_bytes();
    t_split_read();
    t_split_write();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule